// File: doc/BRIEF.md
# Host Serial Port Selector

This block decides, after each hardware reset, which of two host serial interfaces controls the device: a two-wire I2C port or a four-wire SPI port. Both share one active-low slave-select pin. While that pin sits high, the I2C port stays in charge. When the host pulls the pin low three separate times, the block commits to SPI. It then keeps that choice until the next hardware reset, whatever the pin does afterwards.

The block also holds the enable bit for a separate high-speed data capture port. That port shares pins with SPI, so it can only run alongside I2C. The enable bit is therefore forced low as soon as SPI is chosen. The protocol engines are not part of this block. It drives only their select and enable signals.

Top module: `serial_port_select`

## Requirements
- R1: While reset is held and on the first cycle after it, `use_spi`, `choice_locked` and `capture_en` are all 0.
- R2: If `sel_pin_n` stays high after reset, `use_spi` and `choice_locked` stay 0 for as long as it stays high.
- R3: A falling edge on `sel_pin_n` counts when the pin is first sampled low at rising clock edge k, after at least two cycles high. On the third counted edge, `use_spi` and `choice_locked` both become 1 after rising edge k+3 and not before.
- R4: One or two falling edges alone leave `use_spi` and `choice_locked` at 0.
- R5: Once `use_spi` is 1 it stays 1 until reset, and further toggling of `sel_pin_n` has no effect.
- R6: While `use_spi` is 0, a cycle with `cap_wr` at 1 loads `cap_wr_data` into `capture_en`, visible after the next rising edge.
- R7: While `use_spi` is 1, `capture_en` is 0, and writes through `cap_wr` are ignored.
- R8: A `capture_en` that was 1 drops to 0 in the same cycle that `use_spi` becomes 1.
- R9: A new reset returns the block to I2C and restarts the edge count from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| sel_pin_n | input | 1 | Shared slave-select pin, asynchronous, idles high |
| cap_wr | input | 1 | Write strobe for the capture port enable bit |
| cap_wr_data | input | 1 | Value written to the capture port enable bit |
| use_spi | output | 1 | 1 selects SPI, 0 selects I2C |
| choice_locked | output | 1 | 1 once the SPI choice is fixed until reset |
| capture_en | output | 1 | Enable for the high-speed capture port |

## Verification
A pin level first sampled at rising edge k passes two synchronizer flops and the edge register. The counter updates at edge k+2, so the selection outputs change after edge k+3. A write of the capture enable shows after the very next edge. The bench drives every input on the falling clock edge. It checks the selection outputs both one edge before and exactly at edge k+3, which catches a selection that arrives early or late. Capture-enable results are sampled on the falling edge after the single rising edge that should update them.

// File: rtl/serial_port_select.sv
module serial_port_select #(
  parameter int SYNC_STAGES = 2,
  parameter int EDGE_COUNT  = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_pin_n,
  input  logic cap_wr,
  input  logic cap_wr_data,
  output logic use_spi,
  output logic choice_locked,
  output logic capture_en
);
  localparam int CW = $clog2(EDGE_COUNT + 1);
  localparam logic [CW-1:0] TARGET = CW'(EDGE_COUNT);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic [CW-1:0]          edge_cnt;
  logic                   spi_q;
  logic                   cap_q;

  wire pin_s   = sync_q[SYNC_STAGES-1];
  wire fall    = prev_q & ~pin_s;
  wire reached = (edge_cnt == TARGET);

  // Idle-high reset values keep a high pin from looking like an edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q   <= '1;
      prev_q   <= 1'b1;
      edge_cnt <= '0;
      spi_q    <= 1'b0;
      cap_q    <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], sel_pin_n};
      prev_q <= pin_s;
      if (fall && !reached) edge_cnt <= edge_cnt + 1'b1;
      if (reached) spi_q <= 1'b1;
      if (spi_q)       cap_q <= 1'b0;
      else if (cap_wr) cap_q <= cap_wr_data;
    end
  end

  assign use_spi       = spi_q;
  assign choice_locked = spi_q;
  assign capture_en    = cap_q & ~spi_q;
endmodule

// File: rtl/serial_port_select_chk.sv
module serial_port_select_chk #(
  parameter int EDGE_COUNT = 3,
  parameter int CW = $clog2(EDGE_COUNT + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cap_wr,
  input logic          cap_wr_data,
  input logic          use_spi,
  input logic          choice_locked,
  input logic          capture_en,
  input logic [CW-1:0] edge_cnt
);
  localparam logic [CW-1:0] TARGET = CW'(EDGE_COUNT);

  p_select_on_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(use_spi) |-> ($past(edge_cnt) == TARGET));
  p_lock_with_spi_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(choice_locked) |-> use_spi);
  p_no_early_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_cnt < TARGET) |-> !use_spi);
  p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    use_spi |=> (use_spi && choice_locked));
  p_saturate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_cnt == TARGET) |=> (edge_cnt == TARGET));
  p_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_wr && !use_spi) |=> (use_spi || capture_en == $past(cap_wr_data)));
  p_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    use_spi |-> !capture_en);
endmodule

bind serial_port_select serial_port_select_chk #(.EDGE_COUNT(EDGE_COUNT)) chk_i (
  .clk(clk), .rst_n(rst_n), .cap_wr(cap_wr), .cap_wr_data(cap_wr_data),
  .use_spi(use_spi), .choice_locked(choice_locked), .capture_en(capture_en),
  .edge_cnt(edge_cnt)
);

// File: tb/serial_port_select_tb_top.sv
module serial_port_select_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_pin_n = 1'b1;
  logic cap_wr = 1'b0;
  logic cap_wr_data = 1'b0;
  logic use_spi, choice_locked, capture_en;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  serial_port_select dut_i (
    .clk(clk), .rst_n(rst_n), .sel_pin_n(sel_pin_n), .cap_wr(cap_wr),
    .cap_wr_data(cap_wr_data), .use_spi(use_spi),
    .choice_locked(choice_locked), .capture_en(capture_en)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    sel_pin_n = 1'b1;
    cap_wr = 1'b0;
    tick(2);
    rst_n = 1'b1;
  endtask

  task automatic pulse_low();
    sel_pin_n = 1'b0;
    tick(4);
    sel_pin_n = 1'b1;
    tick(4);
  endtask

  task automatic write_cap(input logic v);
    cap_wr = 1'b1;
    cap_wr_data = v;
    tick(1);
    cap_wr = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_n = 1'b0;
    tick(1);
    chk("R1 spi in reset", use_spi, 1'b0);
    chk("R1 lock in reset", choice_locked, 1'b0);
    chk("R1 capture in reset", capture_en, 1'b0);
    rst_n = 1'b1;
    tick(1);
    chk("R1 spi after reset", use_spi, 1'b0);
    chk("R1 capture after reset", capture_en, 1'b0);
  endtask

  task automatic t_idle_high();
    do_reset();
    tick(50);
    chk("R2 idle spi", use_spi, 1'b0);
    chk("R2 idle lock", choice_locked, 1'b0);
  endtask

  task automatic t_cap_write();
    do_reset();
    write_cap(1'b1);
    chk("R6 write one", capture_en, 1'b1);
    write_cap(1'b0);
    chk("R6 write zero", capture_en, 1'b0);
    write_cap(1'b1);
    chk("R6 write one again", capture_en, 1'b1);
  endtask

  task automatic t_three_edges();
    pulse_low();
    pulse_low();
    tick(20);
    chk("R4 two edges spi", use_spi, 1'b0);
    chk("R4 two edges lock", choice_locked, 1'b0);
    chk("R4 capture kept", capture_en, 1'b1);
    sel_pin_n = 1'b0;
    tick(3);
    chk("R3 not before k+3", use_spi, 1'b0);
    chk("R8 capture before select", capture_en, 1'b1);
    tick(1);
    chk("R3 spi at k+3", use_spi, 1'b1);
    chk("R3 lock at k+3", choice_locked, 1'b1);
    chk("R8 capture cleared", capture_en, 1'b0);
    sel_pin_n = 1'b1;
    tick(4);
  endtask

  task automatic t_after_lock();
    for (int i = 0; i < 5; i++) pulse_low();
    chk("R5 spi held", use_spi, 1'b1);
    chk("R5 lock held", choice_locked, 1'b1);
    write_cap(1'b1);
    chk("R7 write ignored", capture_en, 1'b0);
    tick(3);
    chk("R7 capture stays off", capture_en, 1'b0);
  endtask

  task automatic t_rereset();
    do_reset();
    tick(1);
    chk("R9 spi cleared", use_spi, 1'b0);
    chk("R9 lock cleared", choice_locked, 1'b0);
    pulse_low();
    tick(10);
    chk("R9 count restarted", use_spi, 1'b0);
    write_cap(1'b1);
    chk("R9 capture usable", capture_en, 1'b1);
  endtask

  initial begin
    t_reset();
    t_idle_high();
    t_cap_write();
    t_three_edges();
    t_after_lock();
    t_rereset();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule